// File: doc/BRIEF.md
# Suspendable Host Byte-Write Sequencer

This block takes single-byte writes from a host processor and carries them into either a display frame SRAM or a small bank of display control registers. The host presents an address and a data byte, drops its chip select and then its write-byte-enable, and waits for `host_ready`. The sequencer only works while the bus handover logic grants it the shared memory buses (`bus_grant`). It first lets the external bus buffers settle, then pulses the SRAM write strobe for a fixed width, and then holds ready high until the host ends the cycle.

The display scan-out may take the buses back at any moment. When the grant is withdrawn during the settle phase or the strobe phase, the strobe is released at once and the write is parked. When the grant returns, the settle count starts again from zero, the strobe is given its full width, and only then is ready raised. Because of this, the host never sees ready for a write that did not fully complete.

The address decoder sends the upper half of the address space to the register bank. That bank holds four 6-bit palette colours, a scan-line offset and a visible line count. Registers cannot be read back. A register takes its new value at the same edge where the SRAM strobe would rise.

Top module: `hwr_ctrl`

States: `ST_IDLE` (strobe high, ready low), `ST_BUFW` (buffer settle count), `ST_WRITE` (strobe low, pulse count), `ST_ACK` (ready high).
Transitions:
- idle→bufw on a request: grant high, chip select low and write-byte-enable low. The counter is cleared.
- bufw→write once the count reaches `BUF_WAIT`. The strobe goes low.
- bufw→bufw (park) while the grant is low. The counter is held at zero.
- write→ack once the count reaches `PULSE`. The strobe rises, ready rises and the register commit happens.
- write→bufw (suspend) when the grant drops. The strobe is released.
- ack→idle when write-byte-enable is high. Ready falls.

## Requirements
- R1: After reset, `sram_we_n` is 1 and `host_ready` is 0. All palette entries are 0, `line_offset` is 0 and `line_count` is 240.
- R2: The sequencer leaves idle only on a clock edge where `bus_grant`=1, `host_cs_n`=0 and `host_wbe_n`=0. On any other input combination, no strobe and no ready are produced.
- R3: With the grant held, `sram_we_n` goes low on the (BUF_WAIT+2)th rising edge counted from the edge that samples the request. It stays low for PULSE+1 cycles; with the defaults, that is the 4th edge and 4 cycles.
- R4: `host_ready` rises on the same edge where `sram_we_n` returns high after a full pulse, which is the 8th edge with the defaults. It is never high while `sram_we_n` is low.
- R5: If `bus_grant` is 0 at an edge while in the settle or strobe phase, `sram_we_n` is 1 after that edge and ready stays 0. After the grant returns, the settle count restarts from zero: the strobe falls on the 3rd edge, lasts PULSE+1 cycles, and ready follows on the 7th edge.
- R6: Ready stays high as long as `host_wbe_n` is 0. It falls on the first edge that samples `host_wbe_n`=1, and the sequencer returns to idle.
- R7: An address with its top bit equal to 0 targets the SRAM and drives `sram_cs_n` low. An address with its top bit equal to 1 targets the registers and holds `sram_cs_n` high. `sram_addr` carries the remaining lower address bits.
- R8: For register writes, address bits [2:0] choose the target: 0 to 3 select palette entries 0 to 3, which take data bits [5:0] (red [5:4], green [3:2], blue [1:0]); 4 selects `line_offset`; 5 selects `line_count`. Both of these take all 8 bits. Palette entry i appears at `pal_colors[6i+5:6i]`.
- R9: Register writes to offsets 6 and 7 change no register.
- R10: A register changes only at the edge where ready rises. A parked or still-running write leaves it untouched, and SRAM-region writes never change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_grant | input | 1 | Bus handover logic lets the sequencer own the buses |
| host_cs_n | input | 1 | Host chip select, active low |
| host_wbe_n | input | 1 | Host write-byte-enable, active low |
| host_addr | input | ADDR_W (16) | Host byte address |
| host_data | input | DATA_W (8) | Host write data |
| host_ready | output | 1 | Write completed, held until the host ends the cycle |
| sram_we_n | output | 1 | SRAM write strobe, active low |
| sram_cs_n | output | 1 | SRAM chip select, low only for the SRAM region |
| sram_addr | output | ADDR_W-1 (15) | SRAM byte address |
| pal_colors | output | PAL_N*COLOR_W (24) | Four packed 6-bit palette colours |
| line_offset | output | DATA_W (8) | Scan-line start offset |
| line_count | output | DATA_W (8) | Number of visible lines |

## Verification
The bench targets four kinds of faults:
- **Grant withdrawn mid-strobe and mid-settle.** A design that ignores the loss would keep the strobe low on a bus it no longer owns. One that resumes without restarting the count would strobe on the 1st edge after the grant returns instead of the 3rd. One that acknowledges early would raise ready with no full pulse behind it.
- **Ready held across a long host hold.** A design that drops ready by a timer instead of by the write-byte-enable would fall early.
- **Partial requests.** Chip select alone or enable alone must not start a write.
- **Register side.** The unused offsets 6 and 7 and an aliased address are exercised. A register committed at strobe start would show its new value while the strobe is still low or while the write is parked.

// File: rtl/hwr_pkg.sv
package hwr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BUFW  = 2'd1,
        ST_WRITE = 2'd2,
        ST_ACK   = 2'd3
    } wr_state_e;

endpackage

// File: rtl/hwr_addr_decode.sv
module hwr_addr_decode #(
    parameter int ADDR_W = 16,
    parameter int SEL_W  = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              is_reg,
    output logic              sram_cs_n,
    output logic [SEL_W-1:0]  reg_sel,
    output logic [ADDR_W-2:0] sram_addr
);

    // Top address bit splits SRAM (0) from the register bank (1).
    always_comb begin
        is_reg    = addr[ADDR_W-1];
        sram_cs_n = addr[ADDR_W-1];
        reg_sel   = addr[SEL_W-1:0];
        sram_addr = addr[ADDR_W-2:0];
    end

endmodule

// File: rtl/hwr_seq.sv
module hwr_seq
    import hwr_pkg::*;
#(
    parameter int BUF_WAIT = 2,
    parameter int PULSE    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant,
    input  logic cs_n,
    input  logic wbe_n,
    output logic we_n,
    output logic ready,
    output logic commit
);

    localparam int CNT_MAX = (BUF_WAIT > PULSE) ? BUF_WAIT : PULSE;
    localparam int CNT_W   = $clog2(CNT_MAX + 1) + 1;

    wr_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             we_d, rdy_d;

    // Next state, counter and output values.
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        we_d   = we_n;
        rdy_d  = ready;
        commit = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                we_d  = 1'b1;
                rdy_d = 1'b0;
                if (grant && !cs_n && !wbe_n) begin
                    st_d  = ST_BUFW;
                    cnt_d = '0;
                end
            end
            ST_BUFW: begin
                if (!grant) begin
                    we_d  = 1'b1;
                    cnt_d = '0;
                end else if (cnt_q >= CNT_W'(BUF_WAIT)) begin
                    we_d  = 1'b0;
                    cnt_d = '0;
                    st_d  = ST_WRITE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_WRITE: begin
                if (!grant) begin
                    we_d  = 1'b1;
                    cnt_d = '0;
                    st_d  = ST_BUFW;
                end else if (cnt_q >= CNT_W'(PULSE)) begin
                    we_d   = 1'b1;
                    rdy_d  = 1'b1;
                    commit = 1'b1;
                    st_d   = ST_ACK;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_ACK: begin
                if (wbe_n) begin
                    rdy_d = 1'b0;
                    st_d  = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Output registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_n  <= 1'b1;
            ready <= 1'b0;
        end else begin
            we_n  <= we_d;
            ready <= rdy_d;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> (we_n && !ready));

    assert_leave_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_IDLE) && !(grant && !cs_n && !wbe_n)) |=> (st_q == ST_IDLE));

    assert_ready_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> we_n);

    assert_ready_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(st_q == ST_WRITE));

    assert_grant_loss_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !grant |=> we_n);

    assert_ready_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(wbe_n));

endmodule

// File: rtl/hwr_regbank.sv
module hwr_regbank #(
    parameter int PAL_N      = 4,
    parameter int COLOR_W    = 6,
    parameter int DATA_W     = 8,
    parameter int SEL_W      = 3,
    parameter int HEIGHT_RST = 240,
    parameter int VOFF_RST   = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [SEL_W-1:0]         sel,
    input  logic [DATA_W-1:0]        wdata,
    output logic [PAL_N*COLOR_W-1:0] pal_flat,
    output logic [DATA_W-1:0]        voff,
    output logic [DATA_W-1:0]        height
);

    localparam int VOFF_IDX   = PAL_N;
    localparam int HEIGHT_IDX = PAL_N + 1;

    for (genvar gi = 0; gi < PAL_N; gi++) begin : g_pal
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pal_flat[gi*COLOR_W +: COLOR_W] <= '0;
            end else if (wr_en && (sel == SEL_W'(gi))) begin
                pal_flat[gi*COLOR_W +: COLOR_W] <= wdata[COLOR_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            voff   <= DATA_W'(VOFF_RST);
            height <= DATA_W'(HEIGHT_RST);
        end else if (wr_en) begin
            if (sel == SEL_W'(VOFF_IDX))   voff   <= wdata;
            if (sel == SEL_W'(HEIGHT_IDX)) height <= wdata;
        end
    end

    assert_unused_offsets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (sel > SEL_W'(HEIGHT_IDX))) |=>
            ($stable(pal_flat) && $stable(voff) && $stable(height)));

    assert_quiet_bank_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(pal_flat) && $stable(voff) && $stable(height)));

endmodule

// File: rtl/hwr_ctrl.sv
module hwr_ctrl #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int PAL_N      = 4,
    parameter int COLOR_W    = 6,
    parameter int BUF_WAIT   = 2,
    parameter int PULSE      = 3,
    parameter int HEIGHT_RST = 240,
    parameter int VOFF_RST   = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_grant,
    input  logic                     host_cs_n,
    input  logic                     host_wbe_n,
    input  logic [ADDR_W-1:0]        host_addr,
    input  logic [DATA_W-1:0]        host_data,
    output logic                     host_ready,
    output logic                     sram_we_n,
    output logic                     sram_cs_n,
    output logic [ADDR_W-2:0]        sram_addr,
    output logic [PAL_N*COLOR_W-1:0] pal_colors,
    output logic [DATA_W-1:0]        line_offset,
    output logic [DATA_W-1:0]        line_count
);

    localparam int SEL_W = $clog2(PAL_N + 2);

    logic             is_reg;
    logic [SEL_W-1:0] reg_sel;
    logic             commit;

    hwr_addr_decode #(
        .ADDR_W (ADDR_W),
        .SEL_W  (SEL_W)
    ) u_dec (
        .addr      (host_addr),
        .is_reg    (is_reg),
        .sram_cs_n (sram_cs_n),
        .reg_sel   (reg_sel),
        .sram_addr (sram_addr)
    );

    hwr_seq #(
        .BUF_WAIT (BUF_WAIT),
        .PULSE    (PULSE)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .grant  (bus_grant),
        .cs_n   (host_cs_n),
        .wbe_n  (host_wbe_n),
        .we_n   (sram_we_n),
        .ready  (host_ready),
        .commit (commit)
    );

    hwr_regbank #(
        .PAL_N      (PAL_N),
        .COLOR_W    (COLOR_W),
        .DATA_W     (DATA_W),
        .SEL_W      (SEL_W),
        .HEIGHT_RST (HEIGHT_RST),
        .VOFF_RST   (VOFF_RST)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (commit && is_reg),
        .sel      (reg_sel),
        .wdata    (host_data),
        .pal_flat (pal_colors),
        .voff     (line_offset),
        .height   (line_count)
    );

    // Register traffic must never leave the SRAM selected during a strobe.
    assert_reg_no_sram_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_n && host_addr[ADDR_W-1]) |-> sram_cs_n);

endmodule

// File: tb/test_hwr_ctrl.sv
module test_hwr_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_grant = 1'b0;
    logic        host_cs_n = 1'b1;
    logic        host_wbe_n = 1'b1;
    logic [15:0] host_addr = '0;
    logic [7:0]  host_data = '0;
    logic        host_ready;
    logic        sram_we_n;
    logic        sram_cs_n;
    logic [14:0] sram_addr;
    logic [23:0] pal_colors;
    logic [7:0]  line_offset;
    logic [7:0]  line_count;

    int total = 0;
    int bad = 0;

    logic [5:0] m_pal [4];
    logic [7:0] m_voff;
    logic [7:0] m_height;

    typedef struct packed {
        logic [15:0] a;
        logic [7:0]  d;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{16'h0000, 8'h5A}, '{16'h8000, 8'hFF}, '{16'h8001, 8'h2D},
        '{16'h8002, 8'h12}, '{16'h8003, 8'hC7}, '{16'h8004, 8'h11},
        '{16'h8005, 8'h55}, '{16'h8006, 8'hAA}, '{16'h8007, 8'h33},
        '{16'h7FFF, 8'h01}, '{16'h800D, 8'h99}
    };

    always #10 clk = ~clk;

    hwr_ctrl i_hwr_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_grant   (bus_grant),
        .host_cs_n   (host_cs_n),
        .host_wbe_n  (host_wbe_n),
        .host_addr   (host_addr),
        .host_data   (host_data),
        .host_ready  (host_ready),
        .sram_we_n   (sram_we_n),
        .sram_cs_n   (sram_cs_n),
        .sram_addr   (sram_addr),
        .pal_colors  (pal_colors),
        .line_offset (line_offset),
        .line_count  (line_count)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit regs_match();
        bit ok = (line_offset == m_voff) && (line_count == m_height);
        for (int i = 0; i < 4; i++) ok = ok && (pal_colors[i*6 +: 6] == m_pal[i]);
        return ok;
    endfunction

    function automatic void model_write(input logic [15:0] a, input logic [7:0] d);
        if (a[15]) begin
            case (a[2:0])
                3'd0, 3'd1, 3'd2, 3'd3: m_pal[a[1:0]] = d[5:0];
                3'd4: m_voff = d;
                3'd5: m_height = d;
                default: ;
            endcase
        end
    endfunction

    // Walk edges until ready; counts edges and strobe-low samples.
    task automatic run_to_ready(input bit exp_cs_n, output int edges, output int lows,
                                output bit cs_ok, output bit early_ok);
        bit done = 0;
        edges = 0; lows = 0; cs_ok = 1; early_ok = 1;
        while (!done && edges < 60) begin
            @(posedge clk); edges++;
            @(negedge clk);
            if (!sram_we_n) begin
                lows++;
                if (sram_cs_n != exp_cs_n) cs_ok = 0;
                if (!regs_match()) early_ok = 0;
            end
            if (host_ready) done = 1;
        end
    endtask

    task automatic request(input logic [15:0] a, input logic [7:0] d);
        host_addr = a; host_data = d; host_cs_n = 1'b0; host_wbe_n = 1'b0;
    endtask

    task automatic release_host();
        host_cs_n = 1'b1; host_wbe_n = 1'b1;
    endtask

    initial begin
        #4000000;
        total++; bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int edges, lows, nlow, nrdy;
        bit cs_ok, early_ok, ok;
        for (int i = 0; i < 4; i++) m_pal[i] = '0;
        m_voff = 8'd0; m_height = 8'd240;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(sram_we_n == 1'b1, "R1 we_n after reset", sram_we_n, 1);
        check(host_ready == 1'b0, "R1 ready after reset", host_ready, 0);
        check(regs_match(), "R1 register reset values", line_count, 240);

        // Table walk: R3 R4 R7 R8 R9 R10
        bus_grant = 1'b1;
        for (int v = 0; v < NV; v++) begin
            request(VECS[v].a, VECS[v].d);
            run_to_ready(VECS[v].a[15], edges, lows, cs_ok, early_ok);
            check(lows == 4, "R3 strobe width", lows, 4);
            check(edges == 8, "R4 edges to ready", edges, 8);
            check(cs_ok, "R7 sram_cs_n during strobe", sram_cs_n, VECS[v].a[15]);
            check(early_ok, "R10 register unchanged before ready", 0, 1);
            check(sram_addr == VECS[v].a[14:0], "R7 sram_addr", sram_addr, VECS[v].a[14:0]);
            model_write(VECS[v].a, VECS[v].d);
            check(regs_match(), "R8 R9 register contents", line_count, m_height);
            release_host();
            @(posedge clk); @(negedge clk);
            check(host_ready == 1'b0, "R6 ready drops after wbe_n high", host_ready, 0);
        end

        // R6: long host hold keeps ready, no new write after return to idle
        request(16'h0010, 8'h01);
        run_to_ready(1'b0, edges, lows, cs_ok, early_ok);
        ok = 1;
        repeat (5) begin @(negedge clk); if (!host_ready) ok = 0; end
        check(ok, "R6 ready held while wbe_n low", host_ready, 1);
        release_host();
        @(posedge clk); @(negedge clk);
        check(host_ready == 1'b0, "R6 ready falls one edge after release", host_ready, 0);
        nlow = 0;
        repeat (8) begin @(negedge clk); if (!sram_we_n || host_ready) nlow++; end
        check(nlow == 0, "R6 idle after completion", nlow, 0);

        // R2: partial requests start nothing
        host_cs_n = 1'b0; host_wbe_n = 1'b1;
        nlow = 0;
        repeat (8) begin @(negedge clk); if (!sram_we_n || host_ready) nlow++; end
        check(nlow == 0, "R2 chip select alone", nlow, 0);
        host_cs_n = 1'b1; host_wbe_n = 1'b0;
        nlow = 0;
        repeat (8) begin @(negedge clk); if (!sram_we_n || host_ready) nlow++; end
        check(nlow == 0, "R2 enable alone", nlow, 0);
        bus_grant = 1'b0;
        request(16'h0020, 8'h02);
        nlow = 0;
        repeat (8) begin @(negedge clk); if (!sram_we_n || host_ready) nlow++; end
        check(nlow == 0, "R2 no grant", nlow, 0);
        bus_grant = 1'b1;
        run_to_ready(1'b0, edges, lows, cs_ok, early_ok);
        check(edges == 8, "R2 start once grant arrives", edges, 8);
        release_host();
        @(posedge clk); @(negedge clk);

        // R5 R10: grant lost during strobe on a register write
        request(16'h8004, 8'h77);
        edges = 0;
        while (sram_we_n && edges < 20) begin @(posedge clk); edges++; @(negedge clk); end
        check(edges == 4, "R3 strobe fall edge", edges, 4);
        bus_grant = 1'b0;
        @(posedge clk); @(negedge clk);
        check(sram_we_n == 1'b1, "R5 strobe released on grant loss", sram_we_n, 1);
        nlow = 0; nrdy = 0;
        repeat (6) begin
            @(negedge clk);
            if (!sram_we_n) nlow++;
            if (host_ready) nrdy++;
        end
        check(nlow == 0, "R5 strobe stays high while parked", nlow, 0);
        check(nrdy == 0, "R5 no ready while parked", nrdy, 0);
        check(line_offset == m_voff, "R10 parked write not committed", line_offset, m_voff);
        bus_grant = 1'b1;
        run_to_ready(1'b1, edges, lows, cs_ok, early_ok);
        check(edges == 7, "R5 resume edges to ready", edges, 7);
        check(lows == 4, "R5 resumed strobe full width", lows, 4);
        check(early_ok, "R10 no commit before ready after resume", 0, 1);
        model_write(16'h8004, 8'h77);
        check(line_offset == 8'h77, "R10 committed after ready", line_offset, 8'h77);
        release_host();
        @(posedge clk); @(negedge clk);

        // R5: grant lost during buffer settle
        request(16'h0030, 8'h03);
        @(posedge clk); @(negedge clk);
        bus_grant = 1'b0;
        nlow = 0;
        repeat (6) begin @(negedge clk); if (!sram_we_n || host_ready) nlow++; end
        check(nlow == 0, "R5 park in settle phase", nlow, 0);
        bus_grant = 1'b1;
        run_to_ready(1'b0, edges, lows, cs_ok, early_ok);
        check(edges == 7, "R5 settle restart edges", edges, 7);
        check(lows == 4, "R5 settle restart strobe", lows, 4);
        release_host();
        @(posedge clk); @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule